// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches a bank of general-purpose input lines and turns per-line conditions into interrupt requests. Each line is first brought into the clock domain through a two-stage synchronizer. It may then pass through an optional per-line glitch filter that advances only on an external sampling pulse. The line is then classified according to two per-line configuration bits. The first bit picks edge or level sensitivity. The second bit picks the active direction, which is rising or high when set and falling or low when clear.

Edge events are held in a sticky latch until software writes ones to the clear register. Level conditions follow the line continuously. Per-line enable bits decide whether a line takes part at all. Per-line mask bits hide a participating line from the status word and from the interrupt output, while detection continues underneath. A single registered interrupt output is raised whenever any status bit is set.

Configuration and status use a flat register port. It has a write strobe with an address and data word, and the read data is returned combinationally for the presented address. Toggling the active direction to emulate both-edge triggering is left to software.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register reads 0, the status and raw words read 0, and `irq_out` is low.
- R2: Address 0 holds enable, 1 holds mask, 2 holds the sensitivity kind (1 = edge, 0 = level), 3 holds the direction (1 = rising/high, 0 = falling/low), and 4 holds the filter enable. Each reads back as written. Address 5 reads the status word, 6 reads the raw word (enabled and pending, before masking), and 7 is the clear register, which reads 0. Writes to 5 and 6 change nothing.
- R3: A level-high line (kind 0, direction 1) shows in status exactly two clock edges after its input rises, and leaves status two edges after the input falls.
- R4: A level-low line (kind 0, direction 0) shows in status while its synchronized input is 0.
- R5: A rising-edge line (kind 1, direction 1) latches on a 0-to-1 transition and stays pending after the input returns low.
- R6: A falling-edge line (kind 1, direction 0) latches on a 1-to-0 transition and ignores the rising transition.
- R7: Writing the clear register clears the latched edge of every line whose data bit is 1. Lines whose bit is 0 keep their latch. A level-mode line is not affected by a clear write.
- R8: If a new edge and a clear write hit the same line in the same cycle, the line stays pending.
- R9: A mask bit of 1 removes the line from status and `irq_out` but not from the raw word. Unmasking a line exposes an edge that was latched while it was masked.
- R10: A line whose enable bit is 0 is absent from raw and status, latches no edge, and loses any latched edge when it is disabled.
- R11: `irq_out` equals the OR of the status word one clock earlier.
- R12: With its filter bit set, a line's effective value changes only after the synchronized input has differed from it at 2 consecutive `db_tick` pulses. A shorter excursion is discarded. Without `db_tick` pulses the filtered value never moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINES | Asynchronous input lines |
| db_tick | input | 1 | One-cycle sampling pulse for the glitch filters |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Read data for `reg_addr` |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The clear write and the edge latch can act on the same line in one cycle. The bench first leaves line 0 with an edge already latched. It then lets the line rise again and times the clear write so that the write strobe is sampled on the same clock edge at which the synchronized rising transition is detected. The line must still read pending afterwards, and a later clear write alone must empty it. A checker property watches the same race on every line throughout the run.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RG_EN    = 3'd0,
        RG_MASK  = 3'd1,
        RG_KIND  = 3'd2,
        RG_POL   = 3'd3,
        RG_FILT  = 3'd4,
        RG_STAT  = 3'd5,
        RG_RAW   = 3'd6,
        RG_CLEAR = 3'd7
    } reg_sel_e;

    typedef enum logic {
        DB_SETTLED  = 1'b0,
        DB_COUNTING = 1'b1
    } db_state_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int DB_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_tick,
    input  logic [WIDTH-1:0] sync_in,
    output logic [WIDTH-1:0] filt_out
);
    localparam int CNT_W = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_TICKS - 1);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        db_state_e        st_q, st_d;
        logic [CNT_W-1:0] cnt_q, cnt_d;
        logic             val_q, val_d;
        logic             differs;

        assign differs = sync_in[g] ^ val_q;

        // state register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q  <= DB_SETTLED;
                cnt_q <= '0;
                val_q <= 1'b0;
            end else begin
                st_q  <= st_d;
                cnt_q <= cnt_d;
                val_q <= val_d;
            end
        end

        // next state and filtered value
        always_comb begin
            st_d  = st_q;
            cnt_d = cnt_q;
            val_d = val_q;
            unique case (st_q)
                DB_SETTLED: begin
                    if (db_tick && differs) begin
                        if (DB_TICKS <= 1) begin
                            val_d = sync_in[g];
                        end else begin
                            st_d  = DB_COUNTING;
                            cnt_d = CNT_W'(1);
                        end
                    end
                end
                DB_COUNTING: begin
                    if (db_tick) begin
                        if (!differs) begin
                            st_d  = DB_SETTLED;
                            cnt_d = '0;
                        end else if (cnt_q == CNT_LAST) begin
                            st_d  = DB_SETTLED;
                            cnt_d = '0;
                            val_d = sync_in[g];
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
            endcase
        end

        assign filt_out[g] = val_q;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_v,
    input  logic [WIDTH-1:0] kind_edge,
    input  logic [WIDTH-1:0] pol_high,
    input  logic [WIDTH-1:0] en_v,
    input  logic [WIDTH-1:0] clr_v,
    output logic [WIDTH-1:0] hit_v,
    output logic [WIDTH-1:0] latch_v,
    output logic [WIDTH-1:0] raw_v
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] rise_v, fall_v, lvl_act, pend_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= line_v;
            // a fresh edge is ORed after the clear so it survives a same-cycle clear
            latch_q <= (latch_q & ~clr_v & en_v) | (hit_v & en_v);
        end
    end

    always_comb begin
        rise_v  = line_v & ~prev_q;
        fall_v  = ~line_v & prev_q;
        hit_v   = kind_edge & ((pol_high & rise_v) | (~pol_high & fall_v));
        lvl_act = ~(line_v ^ pol_high);
        pend_v  = (kind_edge & latch_q) | (~kind_edge & lvl_act);
        raw_v   = en_v & pend_v;
    end

    assign latch_v = latch_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int N_LINES  = 32,
    parameter int DB_TICKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LINES-1:0]   line_in,
    input  logic                 db_tick,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [N_LINES-1:0]   reg_wdata,
    output logic [N_LINES-1:0]   reg_rdata,
    output logic                 irq_out
);
    logic [N_LINES-1:0] en_q, mask_q, kind_q, pol_q, filt_en_q;
    logic [N_LINES-1:0] sync_v, filt_v, dsel_v;
    logic [N_LINES-1:0] edge_hit, edge_lat, raw_v, status_v, eoi_vec;
    logic               eoi_wr;
    logic               irq_q;
    reg_sel_e           sel;

    assign sel    = reg_sel_e'(reg_addr);
    assign eoi_wr = reg_wr && (sel == RG_CLEAR);
    assign eoi_vec = eoi_wr ? reg_wdata : '0;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            mask_q    <= '0;
            kind_q    <= '0;
            pol_q     <= '0;
            filt_en_q <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                RG_EN:    en_q      <= reg_wdata;
                RG_MASK:  mask_q    <= reg_wdata;
                RG_KIND:  kind_q    <= reg_wdata;
                RG_POL:   pol_q     <= reg_wdata;
                RG_FILT:  filt_en_q <= reg_wdata;
                RG_STAT, RG_RAW, RG_CLEAR: ;
            endcase
        end
    end

    gpio_irq_sync #(.WIDTH(N_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (sync_v)
    );

    gpio_irq_debounce #(.WIDTH(N_LINES), .DB_TICKS(DB_TICKS)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .db_tick  (db_tick),
        .sync_in  (sync_v),
        .filt_out (filt_v)
    );

    assign dsel_v = (filt_en_q & filt_v) | (~filt_en_q & sync_v);

    gpio_irq_detect #(.WIDTH(N_LINES)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_v    (dsel_v),
        .kind_edge (kind_q),
        .pol_high  (pol_q),
        .en_v      (en_q),
        .clr_v     (eoi_vec),
        .hit_v     (edge_hit),
        .latch_v   (edge_lat),
        .raw_v     (raw_v)
    );

    assign status_v = raw_v & ~mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_v;
    end
    assign irq_out = irq_q;

    // read-back
    always_comb begin
        unique case (sel)
            RG_EN:    reg_rdata = en_q;
            RG_MASK:  reg_rdata = mask_q;
            RG_KIND:  reg_rdata = kind_q;
            RG_POL:   reg_rdata = pol_q;
            RG_FILT:  reg_rdata = filt_en_q;
            RG_STAT:  reg_rdata = status_v;
            RG_RAW:   reg_rdata = raw_v;
            RG_CLEAR: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
    parameter int N_LINES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               db_tick,
    input logic               eoi_wr,
    input logic [N_LINES-1:0] eoi_bits,
    input logic [N_LINES-1:0] hit,
    input logic [N_LINES-1:0] edge_lat,
    input logic [N_LINES-1:0] en_bits,
    input logic [N_LINES-1:0] sync_bits,
    input logic [N_LINES-1:0] filt_bits,
    input logic [N_LINES-1:0] status,
    input logic               irq_out
);
    p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) |=> irq_out);

    p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|status) |=> !irq_out);

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> ((edge_lat & $past(eoi_bits) & ~$past(hit)) == '0));

    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((edge_lat & $past(hit & en_bits)) == $past(hit & en_bits)));

    p_disabled_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((edge_lat & ~$past(en_bits)) == '0));

    p_filter_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !db_tick |=> $stable(filt_bits));

    p_filter_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((filt_bits ^ $past(filt_bits)) & (filt_bits ^ $past(sync_bits))) == '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.N_LINES(N_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_tick   (db_tick),
    .eoi_wr    (eoi_wr),
    .eoi_bits  (eoi_vec),
    .hit       (edge_hit),
    .edge_lat  (edge_lat),
    .en_bits   (en_q),
    .sync_bits (sync_v),
    .filt_bits (filt_v),
    .status    (status_v),
    .irq_out   (irq_out)
);

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_in = '0;
    logic         db_tick = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_unit #(.N_LINES(N), .DB_TICKS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .db_tick(db_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); db_tick = 1'b1;
        @(negedge clk); db_tick = 1'b0;
    endtask

    task automatic cfg_clear();
        for (int a = 0; a < 5; a++) wr(3'(a), '0);
        line_in = '0;
        wait_n(4);
        wr(3'd7, '1);
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset addr %0d", a), v, '0);
        end
        chk("R1 reset irq", {31'd0, irq_out}, '0);
    endtask

    task automatic t_regs();
        logic [N-1:0] v;
        logic [N-1:0] pat [5];
        pat[0] = 32'hA5A5_0F0F; pat[1] = 32'h1234_5678; pat[2] = 32'hFFFF_0000;
        pat[3] = 32'h0F0F_F0F0; pat[4] = 32'h8000_0001;
        for (int a = 0; a < 5; a++) wr(3'(a), pat[a]);
        wr(3'd5, '1); wr(3'd6, '1); wr(3'd7, '1);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk($sformatf("R2 readback addr %0d", a), v, pat[a]);
        end
        rd(3'd7, v);
        chk("R2 clear register reads zero", v, '0);
        cfg_clear();
    endtask

    task automatic t_level_high();
        logic [N-1:0] v;
        wr(3'd0, 32'h8); wr(3'd3, 32'h8);
        line_in[3] = 1'b1;
        wait_n(1); rd(3'd5, v); chk("R3 level high one edge", v, '0);
        wait_n(1); rd(3'd5, v); chk("R3 level high two edges", v, 32'h8);
        wr(3'd7, 32'h8);
        rd(3'd5, v); chk("R7 level unaffected by clear", v, 32'h8);
        line_in[3] = 1'b0;
        wait_n(1); rd(3'd5, v); chk("R3 level high release one edge", v, 32'h8);
        wait_n(1); rd(3'd5, v); chk("R3 level high released", v, '0);
        cfg_clear();
    endtask

    task automatic t_level_low();
        logic [N-1:0] v;
        wr(3'd0, 32'h20);
        rd(3'd5, v); chk("R4 level low active", v, 32'h20);
        line_in[5] = 1'b1;
        wait_n(3); rd(3'd5, v); chk("R4 level low inactive", v, '0);
        cfg_clear();
    endtask

    task automatic t_rise();
        logic [N-1:0] v;
        wr(3'd0, 32'h1); wr(3'd2, 32'h1); wr(3'd3, 32'h1);
        line_in[0] = 1'b1; wait_n(4);
        rd(3'd5, v); chk("R5 rising latched", v, 32'h1);
        line_in[0] = 1'b0; wait_n(4);
        rd(3'd5, v); chk("R5 rising sticky", v, 32'h1);
        wr(3'd7, 32'h1);
        rd(3'd5, v); chk("R7 clear rising", v, '0);
        cfg_clear();
    endtask

    task automatic t_fall();
        logic [N-1:0] v;
        wr(3'd0, 32'h2); wr(3'd2, 32'h2);
        line_in[1] = 1'b1; wait_n(4);
        rd(3'd5, v); chk("R6 rising ignored", v, '0);
        line_in[1] = 1'b0; wait_n(4);
        rd(3'd5, v); chk("R6 falling latched", v, 32'h2);
        wr(3'd7, 32'hFFFF_FFFD);
        rd(3'd5, v); chk("R7 zero bit keeps latch", v, 32'h2);
        wr(3'd7, 32'h2);
        rd(3'd5, v); chk("R7 one bit clears latch", v, '0);
        cfg_clear();
    endtask

    task automatic t_race();
        logic [N-1:0] v;
        wr(3'd0, 32'h1); wr(3'd2, 32'h1); wr(3'd3, 32'h1);
        line_in[0] = 1'b1; wait_n(4);
        line_in[0] = 1'b0; wait_n(4);
        rd(3'd5, v); chk("R8 prior latch present", v, 32'h1);
        line_in[0] = 1'b1;
        wait_n(2);
        reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd5, v); chk("R8 edge wins over clear", v, 32'h1);
        wr(3'd7, 32'h1);
        rd(3'd5, v); chk("R8 later clear empties", v, '0);
        cfg_clear();
    endtask

    task automatic t_mask();
        logic [N-1:0] v;
        wr(3'd0, 32'h4); wr(3'd1, 32'h4); wr(3'd2, 32'h4); wr(3'd3, 32'h4);
        line_in[2] = 1'b1; wait_n(4);
        rd(3'd5, v); chk("R9 masked status", v, '0);
        rd(3'd6, v); chk("R9 masked raw", v, 32'h4);
        chk("R9 masked irq", {31'd0, irq_out}, '0);
        wr(3'd1, '0);
        rd(3'd5, v); chk("R9 unmasked status", v, 32'h4);
        wait_n(1);
        chk("R9 unmasked irq", {31'd0, irq_out}, 32'h1);
        cfg_clear();
    endtask

    task automatic t_enable();
        logic [N-1:0] v;
        wr(3'd2, 32'h10); wr(3'd3, 32'h10);
        line_in[4] = 1'b1; wait_n(4);
        rd(3'd6, v); chk("R10 disabled raw", v, '0);
        line_in[4] = 1'b0; wait_n(4);
        wr(3'd0, 32'h10);
        rd(3'd6, v); chk("R10 no latch while disabled", v, '0);
        line_in[4] = 1'b1; wait_n(4);
        rd(3'd6, v); chk("R10 enabled latch", v, 32'h10);
        wr(3'd0, '0);
        wr(3'd0, 32'h10);
        rd(3'd6, v); chk("R10 disable discards latch", v, '0);
        cfg_clear();
    endtask

    task automatic t_irq();
        logic [N-1:0] v;
        wr(3'd0, 32'h40); wr(3'd3, 32'h40);
        line_in[6] = 1'b1;
        wait_n(2);
        rd(3'd5, v); chk("R11 status up", v, 32'h40);
        chk("R11 irq lags status", {31'd0, irq_out}, '0);
        wait_n(1);
        chk("R11 irq raised", {31'd0, irq_out}, 32'h1);
        line_in[6] = 1'b0;
        wait_n(2);
        chk("R11 irq held one cycle", {31'd0, irq_out}, 32'h1);
        wait_n(1);
        chk("R11 irq dropped", {31'd0, irq_out}, '0);
        cfg_clear();
    endtask

    task automatic t_debounce();
        logic [N-1:0] v;
        wr(3'd0, 32'h80); wr(3'd3, 32'h80); wr(3'd4, 32'h80);
        line_in[7] = 1'b1; wait_n(4);
        rd(3'd5, v); chk("R12 no ticks no change", v, '0);
        pulse_tick();
        rd(3'd5, v); chk("R12 one tick not enough", v, '0);
        pulse_tick();
        rd(3'd5, v); chk("R12 two ticks pass", v, 32'h80);
        line_in[7] = 1'b0; wait_n(3);
        pulse_tick();
        line_in[7] = 1'b1; wait_n(3);
        pulse_tick(); pulse_tick();
        rd(3'd5, v); chk("R12 short low excursion filtered", v, 32'h80);
        line_in[7] = 1'b0; wait_n(3);
        pulse_tick(); pulse_tick();
        rd(3'd5, v); chk("R12 sustained low passes", v, '0);
        cfg_clear();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall();
        t_race();
        t_mask();
        t_enable();
        t_irq();
        t_debounce();
        done = 1'b1;
        report();
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end
endmodule